// File: doc/BRIEF.md
# Two-Level Clear-on-Read Interrupt Hub

This block gathers single-cycle event pulses from a device controller into a two-level interrupt structure and drives one level interrupt request. Ten device-wide events land in the main source register, each one gated by a global enable mask. Every endpoint also has its own register that holds an enable mask and eight event source bits. The main register reports one summary bit per endpoint, so an interrupt handler reads the main register first and then reads only the endpoints it flags.

Reads have side effects. A read of the main register clears every device-wide source bit and drops the request line. A read of an endpoint register clears that endpoint's source bits, and its summary bit goes with them. An event pulse that arrives in the same cycle as the read that clears its register is recorded after the clear, so no event is lost. The register port is a plain single-cycle strobe interface. `rd_data` is combinational and valid in the same cycle as `rd_en`, and clearing takes effect at the clock edge that ends that cycle. The port has no valid/ready handshake and no back-pressure: every access completes in one cycle. The number of endpoints, `NUM_EP`, is a parameter from 3 to 16.

Top module: `irq_hub`

## Requirements
- R1: The global enable register at address 0 holds 10 bits and resets to 0. A write to address 0 stores `wr_data[9:0]`, and a read returns them in bits 9:0 with bits 31:10 reading 0.
- R2: The main register at address 1 has this layout: bit 20+i holds global event i, where `glob_evt` index 0 = CRC5 error, 1 = PID error, 2 = no such endpoint, 3 = suspend, 4 = resume, 5 = attach, 6 = detach, 7 = receive error, 8 = bus reset and 9 = speed negotiation done. Bits 15:0 are endpoint summaries. Bits 31:30 and 19:16 read 0.
- R3: A global event pulse sets its source bit only when enable bit i is 1. A read of address 1 clears all global source bits at the end of the read cycle.
- R4: Main bit n is 1 exactly while endpoint n has any source bit set. Bits for n >= NUM_EP always read 0.
- R5: The register for endpoint n sits at address 16+n. Its enable bits are 29:24, which a write stores from `wr_data[29:24]`. Its source bits are 7:0. All other bits read 0.
- R6: The endpoint event inputs `ep_evt[8n+k]` map to source bit k. Bit 7 is enabled by enable bit 29, bit 5 by 28, bits 4 and 3 by 27, bit 2 by 26, bit 1 by 25 and bit 0 by 24. Bit 6 (setup received) is always recorded. A read of address 16+n clears that endpoint's source bits.
- R7: `irq` goes high in the cycle after any event is recorded. It stays high until a read of address 1. Endpoint reads do not lower it.
- R8: An event recorded in the same cycle as the read that clears its register is kept after the clear, and in that case `irq` stays high.
- R9: After reset all registers read 0 and `irq` is low.
- R10: Addresses 16+n for n >= NUM_EP, and all other unused addresses, read 0 and ignore writes. `rd_data` is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register address |
| rd_en | input | 1 | Read strobe; triggers clear-on-read |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| glob_evt | input | 10 | Device-wide event pulses |
| ep_evt | input | 8*NUM_EP | Endpoint event pulses, 8 per endpoint |
| irq | output | 1 | Interrupt request level |

## Verification
The bench drives events in the same cycle as the reads that clear them. A design that gave clear priority over set would silently lose those events, and a design that skipped the irq update would leave the request line low while a source bit is pending. It also checks that endpoint reads leave `irq` high and that summary bits fall only when the endpoint register is read, which catches designs that tie either one to the wrong read strobe. Masked events, the always-on setup bit and the shared buffer-used enable are exercised under random masks. Together they show up a wrong bit map or an enable gated at the wrong stage. Out-of-range endpoint addresses are written and read to expose any aliasing onto real endpoints.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W      = 5;
  localparam int GEV_W       = 10;
  localparam int MAIN_GEV_LO = 20;
  localparam int EP_SRC_W    = 8;
  localparam int EP_MSK_W    = 6;
  localparam int EP_MSK_LO   = 24;
  localparam int EP_MAX      = 16;
  localparam logic [ADDR_W-1:0] A_GMASK = 5'd0;
  localparam logic [ADDR_W-1:0] A_MAIN  = 5'd1;

  // Expand the six endpoint enable bits onto the eight source bits.
  function automatic logic [EP_SRC_W-1:0] ep_enable(input logic [EP_MSK_W-1:0] m);
    return {m[5], 1'b1, m[4], m[3], m[3], m[2], m[1], m[0]};
  endfunction
endpackage

// File: rtl/irq_glob_bank.sv
module irq_glob_bank
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mask,
  input  logic [GEV_W-1:0] wr_bits,
  input  logic             clr,
  input  logic [GEV_W-1:0] evt,
  output logic [GEV_W-1:0] mask_q,
  output logic [GEV_W-1:0] src_q,
  output logic             rec_any
);
  logic [GEV_W-1:0] new_bits;

  assign new_bits = evt & mask_q;
  assign rec_any  = |new_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      src_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= wr_bits;
      src_q <= (clr ? '0 : src_q) | new_bits;
    end
  end

  p_main_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && new_bits == '0) |=> (src_q == '0));
  p_main_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && new_bits != '0) |=> (src_q == $past(new_bits)));
  p_main_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((src_q & ~$past(src_q) & ~$past(mask_q)) == '0));
endmodule

// File: rtl/irq_ep_slot.sv
module irq_ep_slot
  import irq_hub_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_mask,
  input  logic [EP_MSK_W-1:0] wr_bits,
  input  logic                clr,
  input  logic [EP_SRC_W-1:0] evt,
  output logic [EP_MSK_W-1:0] mask_q,
  output logic [EP_SRC_W-1:0] src_q,
  output logic                pending,
  output logic                rec_any
);
  logic [EP_SRC_W-1:0] new_bits;

  assign new_bits = evt & ep_enable(mask_q);
  assign rec_any  = |new_bits;
  assign pending  = |src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      src_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= wr_bits;
      src_q <= (clr ? '0 : src_q) | new_bits;
    end
  end

  p_ep_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && new_bits == '0) |=> (src_q == '0));
  p_ep_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && new_bits != '0) |=> (src_q == $past(new_bits)));
  p_ep_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((src_q & ~$past(src_q) & ~ep_enable($past(mask_q))) == '0));
endmodule

// File: rtl/irq_req_line.sv
module irq_req_line (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (irq & ~clr) | set;
  end

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_EP = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [4:0]                 addr,
  input  logic                       rd_en,
  input  logic                       wr_en,
  input  logic [31:0]                wr_data,
  output logic [31:0]                rd_data,
  input  logic [GEV_W-1:0]           glob_evt,
  input  logic [NUM_EP*EP_SRC_W-1:0] ep_evt,
  output logic                       irq
);
  localparam logic [4:0] EP_LIMIT = 5'(NUM_EP);

  logic                main_rd, gmask_wr, ep_hit;
  logic [3:0]          ep_idx;
  logic [GEV_W-1:0]    g_mask, g_src;
  logic                g_new;
  logic [EP_MAX-1:0]   ep_pend, ep_new;
  logic [EP_MSK_W-1:0] ep_mask [EP_MAX];
  logic [EP_SRC_W-1:0] ep_src  [EP_MAX];
  logic                wr_unused;

  assign main_rd   = rd_en && (addr == A_MAIN);
  assign gmask_wr  = wr_en && (addr == A_GMASK);
  assign ep_hit    = addr[4];
  assign ep_idx    = addr[3:0];
  assign wr_unused = ^{wr_data[31:30], wr_data[23:10]};

  irq_glob_bank u_glob (
    .clk(clk), .rst_n(rst_n), .wr_mask(gmask_wr), .wr_bits(wr_data[GEV_W-1:0]),
    .clr(main_rd), .evt(glob_evt), .mask_q(g_mask), .src_q(g_src), .rec_any(g_new)
  );

  for (genvar g = 0; g < EP_MAX; g++) begin : g_slot
    if (g < NUM_EP) begin : g_live
      logic sel;
      assign sel = ep_hit && (ep_idx == 4'(g));
      irq_ep_slot u_slot (
        .clk(clk), .rst_n(rst_n), .wr_mask(wr_en && sel),
        .wr_bits(wr_data[EP_MSK_LO +: EP_MSK_W]), .clr(rd_en && sel),
        .evt(ep_evt[g*EP_SRC_W +: EP_SRC_W]), .mask_q(ep_mask[g]),
        .src_q(ep_src[g]), .pending(ep_pend[g]), .rec_any(ep_new[g])
      );
    end else begin : g_off
      assign ep_mask[g] = '0;
      assign ep_src[g]  = '0;
      assign ep_pend[g] = 1'b0;
      assign ep_new[g]  = 1'b0;
    end
  end

  irq_req_line u_req (
    .clk(clk), .rst_n(rst_n), .set(g_new | (|ep_new)), .clr(main_rd), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == A_GMASK)
        rd_data = {{(32-GEV_W){1'b0}}, g_mask};
      else if (addr == A_MAIN)
        rd_data = {2'b00, g_src, 4'b0000, ep_pend};
      else if (ep_hit && ({1'b0, ep_idx} < EP_LIMIT))
        rd_data = {2'b00, ep_mask[ep_idx], 16'h0000, ep_src[ep_idx]};
    end
  end

  p_pend_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_hit && rd_en && !ep_new[ep_idx]) |=> !ep_pend[$past(ep_idx)]);
endmodule

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;
  localparam int NEP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [9:0]  glob_evt = '0;
  logic [NEP*8-1:0] ep_evt = '0;
  logic        irq;

  int n_chk = 0, n_err = 0;

  logic [9:0]  m_gmask = '0, m_gsrc = '0;
  logic        m_irq = 1'b0;
  logic [5:0]  m_epmask [16];
  logic [7:0]  m_epsrc  [16];

  always #2.5 clk = ~clk;

  irq_hub #(.NUM_EP(NEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .glob_evt(glob_evt),
    .ep_evt(ep_evt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [4:0] a, input logic r);
    logic [15:0] pend = '0;
    for (int n = 0; n < NEP; n++) pend[n] = (m_epsrc[n] != 0);
    if (!r) return 32'h0;
    if (a == 5'd0) return {22'h0, m_gmask};
    if (a == 5'd1) return {2'b00, m_gsrc, 4'h0, pend};
    if (a[4] && int'(a[3:0]) < NEP)
      return {2'b00, m_epmask[a[3:0]], 16'h0, m_epsrc[a[3:0]]};
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a == 5'd0) return "R1";
    if (a == 5'd1) return "R2";
    if (a[4] && int'(a[3:0]) < NEP) return "R5";
    return "R10";
  endfunction

  task automatic model_step(input logic [4:0] a, input logic r, input logic w,
                            input logic [31:0] d, input logic [9:0] ge,
                            input logic [NEP*8-1:0] ee);
    logic [9:0] ng;
    logic any;
    ng  = ge & m_gmask;
    any = |ng;
    for (int n = 0; n < NEP; n++) begin
      logic [5:0] m;
      logic [7:0] en, ne;
      m  = m_epmask[n];
      en = {m[5], 1'b1, m[4], m[3], m[3], m[2], m[1], m[0]};
      ne = ee[n*8 +: 8] & en;
      any = any | (|ne);
      m_epsrc[n] = ((r && a == 5'(16+n)) ? 8'h0 : m_epsrc[n]) | ne;
    end
    m_gsrc = ((r && a == 5'd1) ? 10'h0 : m_gsrc) | ng;
    m_irq  = (m_irq && !(r && a == 5'd1)) || any;
    if (w && a == 5'd0) m_gmask = d[9:0];
    for (int n = 0; n < NEP; n++)
      if (w && a == 5'(16+n)) m_epmask[n] = d[29:24];
  endtask

  // One cycle: drive at negedge, check before the edge, update model at the edge.
  task automatic cyc(input logic [4:0] a, input logic r, input logic w,
                     input logic [31:0] d, input logic [9:0] ge,
                     input logic [NEP*8-1:0] ee, input string tag);
    addr = a; rd_en = r; wr_en = w; wr_data = d; glob_evt = ge; ep_evt = ee;
    #1;
    chk("R7 irq", {31'h0, irq}, {31'h0, m_irq});
    if (r) chk(tag == "" ? tag_of(a) : tag, rd_data, exp_rd(a, r));
    @(posedge clk);
    model_step(a, r, w, d, ge, ee);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; glob_evt = '0; ep_evt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(5'd0, 1'b0, 1'b0, 32'h0, 10'h0, '0, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int n = 0; n < 16; n++) begin m_epmask[n] = '0; m_epsrc[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    cyc(5'd0, 1, 0, 0, 0, '0, "R9");
    cyc(5'd1, 1, 0, 0, 0, '0, "R9");
    for (int n = 0; n < NEP; n++) cyc(5'(16+n), 1, 0, 0, 0, '0, "R9");
    // R3: masked global events are dropped
    cyc(5'd0, 0, 0, 0, 10'h3FF, '0, "");
    cyc(5'd1, 1, 0, 0, 0, '0, "R3");
    // R1: enable write and readback width
    cyc(5'd0, 0, 1, 32'hFFFF_FFFF, 0, '0, "");
    cyc(5'd0, 1, 0, 0, 0, '0, "R1");
    // R2: speed negotiation done lands at bit 29
    cyc(5'd0, 0, 0, 0, 10'h200, '0, "");
    cyc(5'd1, 1, 0, 0, 0, '0, "R2");
    cyc(5'd1, 1, 0, 0, 0, '0, "R3");
    // R7: irq holds through endpoint reads, drops on main read
    cyc(5'd0, 0, 0, 0, 10'h001, '0, "");
    idle(3);
    cyc(5'd16, 1, 0, 0, 0, '0, "R7");
    idle(2);
    cyc(5'd1, 1, 0, 0, 0, '0, "R2");
    idle(2);
    // R6: endpoint 0 with enables off keeps only setup bit
    cyc(5'd0, 0, 0, 0, 0, 24'h0000FF, "");
    cyc(5'd1, 1, 0, 0, 0, '0, "R4");
    cyc(5'd16, 1, 0, 0, 0, '0, "R6");
    cyc(5'd1, 1, 0, 0, 0, '0, "R4");
    // R5: endpoint 1 enable write and full capture
    cyc(5'd17, 0, 1, 32'h3F00_0000, 0, '0, "");
    cyc(5'd17, 1, 0, 0, 0, '0, "R5");
    cyc(5'd0, 0, 0, 0, 0, 24'h00FF00, "");
    cyc(5'd17, 1, 0, 0, 0, '0, "R6");
    // R6: buffer-used enable covers two source bits
    cyc(5'd18, 0, 1, 32'h0800_0000, 0, '0, "");
    cyc(5'd0, 0, 0, 0, 0, 24'hFF0000, "");
    cyc(5'd18, 1, 0, 0, 0, '0, "R6");
    // R8: events coincident with clearing reads survive
    cyc(5'd1, 1, 0, 0, 10'h010, '0, "R8");
    cyc(5'd1, 1, 0, 0, 0, '0, "R8");
    cyc(5'd17, 1, 0, 0, 0, 24'h000100, "R8");
    cyc(5'd17, 1, 0, 0, 0, '0, "R8");
    cyc(5'd1, 1, 0, 0, 0, '0, "R8");
    // R10: out-of-range endpoint and unused addresses
    cyc(5'd19, 0, 1, 32'hFFFF_FFFF, 0, '0, "");
    cyc(5'd19, 1, 0, 0, 0, '0, "R10");
    cyc(5'd2, 1, 0, 0, 0, '0, "R10");
    cyc(5'd31, 1, 0, 0, 0, '0, "R10");
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      logic [2:0] s;
      s = 3'($urandom_range(0, 7));
      case (s)
        0: a = 5'd0; 1: a = 5'd1; 2: a = 5'd1; 3: a = 5'd16;
        4: a = 5'd17; 5: a = 5'd18; 6: a = 5'd19; default: a = 5'd2;
      endcase
      cyc(a, ($urandom_range(0, 9) < 4), ($urandom_range(0, 9) == 0), $urandom,
          10'($urandom & $urandom & $urandom),
          24'($urandom & $urandom & $urandom & $urandom), "");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule